// File: doc/BRIEF.md
# SONET Byte Framer with Frame Alignment Pulse

This block sits behind clock and data recovery on a SONET/SDH receive path. It takes the recovered serial line, one bit per bit-clock cycle with the most significant bit of each byte first, and turns it into 8-bit bytes with a byte clock derived by dividing the bit clock by eight. While the out-of-frame input is high, it hunts bit by bit for the framing pattern: an A1 byte (0xF6) directly followed by a run of A2 bytes (0x28).

When the last A2 byte of the required run has arrived (the third by default), the block moves its byte boundary onto that point. It restarts the byte-clock phase there and raises a frame pulse for exactly one byte period. During that period the parallel bus shows that final A2 byte. While out-of-frame is low, the hunt is idle and the existing byte alignment continues unchanged. Everything runs in the bit-clock domain, and reset is synchronous and active high.

Top module: `sonet_frame_aligner`

## Requirements
- R1: While reset is high at a bit-clock edge, `rx_byte` goes to 0x00 and `byte_clk` and `frame_pulse` go low.
- R2: `byte_clk` has a period of 8 bit-clock cycles: high for 4 cycles, then low for 4. `rx_byte` changes only on the bit-clock edge where `byte_clk` rises.
- R3: Each new `rx_byte` value holds the 8 most recent line bits at that byte boundary, with the earliest of them in bit 7.
- R4: While `oof` is low, no frame is detected, no pulse is raised and the byte phase keeps running. Lowering `oof` part-way through a pattern abandons that candidate.
- R5: A frame is found when, with `oof` high, A1 (0xF6) is followed bit-contiguously by `A2_COUNT` consecutive A2 bytes (0x28). `A2_COUNT` defaults to 3.
- R6: If any byte that should continue the A2 run is not 0x28, the candidate is dropped and the hunt resumes bit by bit. No pulse results from that candidate.
- R7: On detection, the byte boundary is placed right after the last bit of the final A2. `rx_byte` shows 0x28 and `byte_clk` restarts its high phase on the next edge. Later bytes are aligned to the new boundary.
- R8: `frame_pulse` rises on the same edge as the realignment and stays high for exactly 8 bit-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial line data, MSB of each byte first |
| oof | input | 1 | Out-of-frame: high arms the frame hunt |
| rx_byte | output | 8 | Parallel received byte |
| byte_clk | output | 1 | Bit clock divided by eight |
| frame_pulse | output | 1 | One-byte-period frame alignment pulse |

## Verification
The bench builds two copies of the block on the same line stimulus. One copy uses the default run of three A2 bytes. The other uses `A2_COUNT` = 2, so a pattern broken after its second A2 is a valid frame for that copy. This shows that the run length really comes from the parameter and is not fixed at three. Both copies receive patterns at several bit offsets, so realignment is exercised from more than one starting phase.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
    localparam int BYTE_W = 8;
    localparam int PH_W   = $clog2(BYTE_W);
    localparam int WIN_W  = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] line_byte_t;

    typedef enum logic {
        HUNT_BITS,
        COUNT_A2
    } hunt_state_e;

    // Byte-lane outputs carried from the phase keeper to the top
    typedef struct packed {
        line_byte_t data;
        logic       bclk;
        logic       pulse;
    } byte_lane_t;

    // High half of the byte period: phases 1..BYTE_W/2
    function automatic logic phase_is_high(input logic [PH_W-1:0] ph);
        return (ph != '0) && (ph <= PH_W'(BYTE_W / 2));
    endfunction
endpackage

// File: rtl/sfa_shifter.sv
module sfa_shifter
    import sfa_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win
);
    always_ff @(posedge clk) begin
        if (rst) win <= '0;
        else     win <= {win[WIN_W-2:0], bit_in};
    end
endmodule

// File: rtl/sfa_hunter.sv
module sfa_hunter
    import sfa_pkg::*;
#(
    parameter line_byte_t SYNC_A1  = 8'hF6,
    parameter line_byte_t SYNC_A2  = 8'h28,
    parameter int         A2_COUNT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             oof,
    input  logic [WIN_W-1:0] win,
    output logic             realign
);
    localparam int CNT_W = $clog2(A2_COUNT + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(A2_COUNT - 1);

    hunt_state_e      st;
    logic [CNT_W-1:0] a2_seen;
    logic [PH_W-1:0]  vph;
    logic             byte_due;
    logic             is_a2;

    assign byte_due = (st == COUNT_A2) && (vph == '0);
    assign is_a2    = (win[BYTE_W-1:0] == SYNC_A2);
    assign realign  = oof && byte_due && is_a2 && (a2_seen == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= HUNT_BITS;
            a2_seen <= '0;
            vph     <= '0;
        end else if (!oof) begin
            st      <= HUNT_BITS;
            a2_seen <= '0;
        end else begin
            unique case (st)
                HUNT_BITS: begin
                    if (win == {SYNC_A1, SYNC_A2}) begin
                        st      <= COUNT_A2;
                        a2_seen <= CNT_W'(1);
                        vph     <= PH_W'(1);
                    end
                end
                COUNT_A2: begin
                    vph <= vph + PH_W'(1);
                    if (byte_due) begin
                        if (is_a2 && a2_seen != LAST_IDX) begin
                            a2_seen <= a2_seen + CNT_W'(1);
                        end else begin
                            st      <= HUNT_BITS;
                            a2_seen <= '0;
                        end
                    end
                end
                default: st <= HUNT_BITS;
            endcase
        end
    end

    // R6
    run_bound_chk: assert property (@(posedge clk) disable iff (rst)
        a2_seen <= LAST_IDX);
    // R4
    idle_when_inframe_chk: assert property (@(posedge clk) disable iff (rst)
        !oof |=> st == HUNT_BITS);
endmodule

// File: rtl/sfa_phaser.sv
module sfa_phaser
    import sfa_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       realign,
    input  line_byte_t last_byte,
    output byte_lane_t lane
);
    logic [PH_W-1:0] ph;
    line_byte_t      data_q;
    logic            pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= '0;
            data_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            ph <= realign ? PH_W'(1) : ph + PH_W'(1);
            if (realign || ph == '0) data_q <= last_byte;
            if (realign)             pulse_q <= 1'b1;
            else if (ph == '0)       pulse_q <= 1'b0;
        end
    end

    assign lane.data  = data_q;
    assign lane.bclk  = phase_is_high(ph);
    assign lane.pulse = pulse_q;

    // R7
    phase_restart_chk: assert property (@(posedge clk) disable iff (rst)
        realign |=> (ph == PH_W'(1)) && pulse_q);
    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        !realign |=> ph == $past(ph) + PH_W'(1));
    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && ph == '0 && !realign) |=> !pulse_q);
endmodule

// File: rtl/sonet_frame_aligner.sv
module sonet_frame_aligner
    import sfa_pkg::*;
#(
    parameter logic [7:0] SYNC_A1  = 8'hF6,
    parameter logic [7:0] SYNC_A2  = 8'h28,
    parameter int         A2_COUNT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_bit,
    input  logic       oof,
    output logic [7:0] rx_byte,
    output logic       byte_clk,
    output logic       frame_pulse
);
    logic [WIN_W-1:0] win;
    logic             realign;
    byte_lane_t       lane;

    sfa_shifter u_shifter (
        .clk    (clk),
        .rst    (rst),
        .bit_in (rx_bit),
        .win    (win)
    );

    sfa_hunter #(
        .SYNC_A1  (SYNC_A1),
        .SYNC_A2  (SYNC_A2),
        .A2_COUNT (A2_COUNT)
    ) u_hunter (
        .clk     (clk),
        .rst     (rst),
        .oof     (oof),
        .win     (win),
        .realign (realign)
    );

    sfa_phaser u_phaser (
        .clk       (clk),
        .rst       (rst),
        .realign   (realign),
        .last_byte (win[BYTE_W-1:0]),
        .lane      (lane)
    );

    assign rx_byte     = lane.data;
    assign byte_clk    = lane.bclk;
    assign frame_pulse = lane.pulse;

    // R4
    pulse_needs_oof_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> $past(oof));
    // R7
    pulse_shows_a2_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_pulse) |-> rx_byte == SYNC_A2);
    // R2
    byte_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> byte_clk);
endmodule

// File: tb/sonet_frame_aligner_bench.sv
module sfa_ref_model #(
    parameter int NEED = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic       oof,
    output logic [7:0] exp_byte,
    output logic       exp_bclk,
    output logic       exp_pulse
);
    bit          q[$];
    int          offs, base, cnt, pleft, n, ph;
    bit          hunting_run, bnd, realn;
    logic [15:0] t;

    function automatic logic [15:0] tail16();
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++)
            if (q.size() > i) v[i] = q[q.size()-1-i];
        return v;
    endfunction

    initial begin
        exp_byte = 8'h00; exp_bclk = 1'b0; exp_pulse = 1'b0;
    end

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); offs = 0; base = 0; cnt = 0; pleft = 0; hunting_run = 0;
            exp_byte = 8'h00; exp_bclk = 1'b0; exp_pulse = 1'b0;
        end else begin
            n = q.size(); t = tail16(); realn = 0;
            if (!oof) hunting_run = 0;
            else if (!hunting_run) begin
                if (t == 16'hF628) begin hunting_run = 1; cnt = 1; base = n; end
            end else if ((n - base) % 8 == 0) begin
                if (t[7:0] == 8'h28) begin
                    if (cnt == NEED - 1) begin realn = 1; hunting_run = 0; end
                    else cnt++;
                end else hunting_run = 0;
            end
            bnd = ((n - offs) % 8 == 0);
            if (realn) begin offs = n; bnd = 1; end
            if (bnd) exp_byte = t[7:0];
            if (realn) pleft = 8;
            else if (pleft > 0) pleft--;
            exp_pulse = (pleft > 0);
            q.push_back(din);
            ph = (q.size() - offs) % 8;
            exp_bclk = (ph >= 1 && ph <= 4);
        end
    end
endmodule

module sonet_frame_aligner_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit = 1'b0;
    logic oof = 1'b1;
    logic [7:0] byte3, byte2, eb3, eb2;
    logic bclk3, bclk2, fp3, fp2, ebc3, ebc2, efp3, efp2;
    int compared = 0, mismatched = 0, cyc = 0;
    int pc3 = 0, pc2 = 0, snap3, snap2;
    bit fp3_prev = 0, fp2_prev = 0, cmp_on = 0, done = 0;

    always #5 clk = ~clk;

    sonet_frame_aligner u_sonet_frame_aligner (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .oof(oof),
        .rx_byte(byte3), .byte_clk(bclk3), .frame_pulse(fp3));

    sonet_frame_aligner #(.A2_COUNT(2)) u_sonet_frame_aligner_n2 (
        .clk(clk), .rst(rst), .rx_bit(rx_bit), .oof(oof),
        .rx_byte(byte2), .byte_clk(bclk2), .frame_pulse(fp2));

    sfa_ref_model #(.NEED(3)) m3 (.clk(clk), .rst(rst), .din(rx_bit), .oof(oof),
        .exp_byte(eb3), .exp_bclk(ebc3), .exp_pulse(efp3));
    sfa_ref_model #(.NEED(2)) m2 (.clk(clk), .rst(rst), .din(rx_bit), .oof(oof),
        .exp_byte(eb2), .exp_bclk(ebc2), .exp_pulse(efp2));

    task automatic check(input string req, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // Per-cycle comparison against the reference models
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            check("R3 rx_byte (A2x3)", byte3, eb3);
            check("R2 byte_clk (A2x3)", bclk3, ebc3);
            check("R8 frame_pulse (A2x3)", fp3, efp3);
            check("R3 rx_byte (A2x2)", byte2, eb2);
            check("R2 byte_clk (A2x2)", bclk2, ebc2);
            check("R8 frame_pulse (A2x2)", fp2, efp2);
            // R7: the pulse rises with the final A2 on the bus
            if (fp3 && !fp3_prev) check("R7 byte at pulse (A2x3)", byte3, 8'h28);
            if (fp2 && !fp2_prev) check("R7 byte at pulse (A2x2)", byte2, 8'h28);
            if (fp3 && !fp3_prev) pc3++;
            if (fp2 && !fp2_prev) pc2++;
            fp3_prev = fp3;
            fp2_prev = fp2;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            rx_bit = b[i];
        end
    endtask

    task automatic send_zeros(input int nbits);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            rx_bit = 1'b0;
        end
    endtask

    task automatic mark();
        snap3 = pc3;
        snap2 = pc2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        check("R1 rx_byte in reset", byte3, 8'h00);
        check("R1 byte_clk in reset", bclk3, 0);
        check("R1 frame_pulse in reset", fp3, 0);
        rst = 1'b0;
        cmp_on = 1;
        send_zeros(40);

        // R5: A1 A1 A2 A2 A2 at a 3-bit offset, oof high
        mark();
        send_zeros(3);
        send_byte(8'hF6); send_byte(8'hF6);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h28);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        send_zeros(16);
        check("R5 one frame found (A2x3)", pc3 - snap3, 1);
        check("R5 one frame found (A2x2)", pc2 - snap2, 1);

        // R4: same pattern with oof low, alignment kept, no pulse
        @(negedge clk); oof = 1'b0;
        mark();
        send_zeros(5);
        send_byte(8'hF6); send_byte(8'hF6);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h28);
        send_byte(8'h44);
        send_zeros(16);
        check("R4 no frame while oof low (A2x3)", pc3 - snap3, 0);
        check("R4 no frame while oof low (A2x2)", pc2 - snap2, 0);

        // R6: run broken after two A2 bytes
        @(negedge clk); oof = 1'b1;
        send_zeros(16);
        mark();
        send_zeros(2);
        send_byte(8'hF6); send_byte(8'h28); send_byte(8'h28);
        send_byte(8'h55);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h28);
        send_zeros(24);
        check("R6 broken run gives no frame (A2x3)", pc3 - snap3, 0);
        check("R6 two-A2 run is a frame (A2x2)", pc2 - snap2, 1);

        // R4: oof dropped part-way through a candidate
        mark();
        send_byte(8'hF6); send_byte(8'h28);
        oof = 1'b0;
        send_byte(8'h28);
        oof = 1'b1;
        send_byte(8'h28);
        send_zeros(24);
        check("R4 oof drop aborts (A2x3)", pc3 - snap3, 0);
        check("R4 oof drop aborts (A2x2)", pc2 - snap2, 0);

        // R7: new alignment at a 5-bit offset, then payload bytes
        mark();
        send_zeros(5);
        send_byte(8'hF6); send_byte(8'hF6); send_byte(8'hF6);
        send_byte(8'h28); send_byte(8'h28); send_byte(8'h28);
        send_byte(8'hAA); send_byte(8'h55); send_byte(8'hC3);
        send_zeros(24);
        check("R7 realigned frame found (A2x3)", pc3 - snap3, 1);
        check("R7 realigned frame found (A2x2)", pc2 - snap2, 1);

        cmp_on = 0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule